// File: doc/BRIEF.md
# TLB Fault Classifier and Capture

This block sits after a translation lookaside buffer. For each completed lookup, from an instruction fetch, a data load or a data store, it decides whether the access must trap. If it must, it reports an exception code and records the values that a trap handler reads to repair the mapping: the faulting virtual address, the address-space identifier, the virtual page number split into a pair-index part and a low two-bit part, and a copy of the pair index for the page-table context.

Lookup results enter on a valid/ready stream. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the result slot is empty or is being emptied in the same cycle, so a stalled consumer stalls the producer with no loss. Fault reports leave on a second valid/ready stream. A report stays present, unchanged, until `flt_ready` accepts it. The recorded context values are plain level outputs. They change only on the edge that takes a faulting request.

Top module: `tlb_fault_unit`

## Requirements
- R1: After reset `flt_valid` is 0, `req_ready` is 1, and every capture output (`cap_badvaddr`, `cap_ehi_asid`, `cap_ehi_vpn2`, `cap_ehi_vpn2x`, `cap_ctx_badvpn2`) is 0.
- R2: Access encoding on `req_access`: 2'b00 = fetch, 2'b01 = load, 2'b10 = store, 2'b11 = load. A request with `req_misaligned` = 1 is an address error in every case: code 5 for a store, code 4 otherwise. This takes precedence over every lookup outcome. Only `cap_badvaddr` is written; the ASID, VPN and context outputs keep their values.
- R3: A request that is not misaligned and has `req_hit` = 0 is a refill fault: code 2 for a fetch, code 3 for a load or store.
- R4: A request that hits with `req_entry_valid` = 0 is an invalid-entry fault: code 2 for a fetch, code 3 for a load or store. This applies even when the entry's dirty bit is 0.
- R5: A store that hits a valid entry with `req_entry_dirty` = 0 is a write-protect fault with code 1. Fetches and loads ignore the dirty bit.
- R6: Every translation fault (codes 1, 2, 3) writes `cap_badvaddr` = vaddr, `cap_ehi_asid` = ASID, `cap_ehi_vpn2` = VPN>>2, `cap_ehi_vpn2x` = VPN[1:0] and `cap_ctx_badvpn2` = VPN>>2, where VPN = vaddr[VA_W-1:PAGE_SHIFT] (bits 31:13 by default).
- R7: A request taken without any fault leaves `flt_valid` low after the edge and changes no capture output.
- R8: `req_ready` = !flt_valid || flt_ready. A report appears on `flt_valid`/`flt_code` right after the edge that takes the request. While `flt_valid` = 1 and `flt_ready` = 0, `flt_valid` and `flt_code` hold and no new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup result present |
| req_ready | output | 1 | Block can take a lookup result |
| req_vaddr | input | VA_W (32) | Virtual address of the access |
| req_asid | input | ASID_W (8) | Current address-space identifier |
| req_access | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| req_misaligned | input | 1 | Address is not aligned for the access size |
| req_hit | input | 1 | Lookup found a matching entry |
| req_entry_valid | input | 1 | Valid bit of the matching entry |
| req_entry_dirty | input | 1 | Writable (dirty) bit of the matching entry |
| flt_valid | output | 1 | Fault report present |
| flt_ready | input | 1 | Consumer takes the fault report |
| flt_code | output | CODE_W (5) | Exception code of the report |
| cap_badvaddr | output | VA_W (32) | Recorded faulting address |
| cap_ehi_asid | output | ASID_W (8) | Recorded ASID |
| cap_ehi_vpn2 | output | VA_W-PAGE_SHIFT-2 (17) | Recorded VPN>>2 |
| cap_ehi_vpn2x | output | 2 | Recorded VPN[1:0] |
| cap_ctx_badvpn2 | output | VA_W-PAGE_SHIFT-2 (17) | Recorded VPN>>2 for the context |

## Verification
A wrong priority or code choice shows on `flt_code` in the cycle right after the request is taken. A wrong capture-enable shows as a capture output that moves after a fault-free or address-error request, or one that fails to move after a translation fault. This is visible at the next edge and stays until the next fault. A broken hold under back-pressure shows as a changed code, or as a dropped or doubled report, while `flt_ready` is low.

// File: rtl/tflt_pkg.sv
package tflt_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_LOAD2 = 2'b11
  } acc_e;

  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] CODE_WRITE_PROT = 5'd1;
  localparam logic [CODE_W-1:0] CODE_FETCH_XLAT = 5'd2;
  localparam logic [CODE_W-1:0] CODE_DATA_XLAT  = 5'd3;
  localparam logic [CODE_W-1:0] CODE_ADDR_RD    = 5'd4;
  localparam logic [CODE_W-1:0] CODE_ADDR_WR    = 5'd5;

  typedef struct packed {
    logic              fault;
    logic              xlat;
    logic [CODE_W-1:0] code;
  } verdict_t;
endpackage

// File: rtl/tflt_vpn_split.sv
module tflt_vpn_split #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 13,
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int PAIR_W    = VPN_W - 2
) (
  input  logic [VA_W-1:0]   vaddr,
  output logic [PAIR_W-1:0] pair_idx,
  output logic [1:0]        low_bits
);
  logic [VPN_W-1:0] vpn;
  assign vpn      = vaddr[VA_W-1:PAGE_SHIFT];
  assign pair_idx = vpn[VPN_W-1:2];
  assign low_bits = vpn[1:0];
endmodule

// File: rtl/tflt_classify.sv
module tflt_classify
  import tflt_pkg::*;
(
  input  acc_e     access,
  input  logic     misaligned,
  input  logic     hit,
  input  logic     entry_valid,
  input  logic     entry_dirty,
  output verdict_t verdict
);
  logic is_store, is_fetch;
  assign is_store = (access == ACC_STORE);
  assign is_fetch = (access == ACC_FETCH);

  always_comb begin
    verdict = '0;
    if (misaligned) begin
      verdict.fault = 1'b1;
      verdict.code  = is_store ? CODE_ADDR_WR : CODE_ADDR_RD;
    end else if (!hit || !entry_valid) begin
      verdict.fault = 1'b1;
      verdict.xlat  = 1'b1;
      verdict.code  = is_fetch ? CODE_FETCH_XLAT : CODE_DATA_XLAT;
    end else if (is_store && !entry_dirty) begin
      verdict.fault = 1'b1;
      verdict.xlat  = 1'b1;
      verdict.code  = CODE_WRITE_PROT;
    end
  end

  // R5
  always_comb begin
    if (verdict.code == CODE_WRITE_PROT)
      wp_store_only_chk: assert (access == ACC_STORE && hit && entry_valid);
  end
endmodule

// File: rtl/tflt_capture.sv
module tflt_capture #(
  parameter int VA_W       = 32,
  parameter int ASID_W     = 8,
  parameter int PAGE_SHIFT = 13,
  localparam int PAIR_W    = VA_W - PAGE_SHIFT - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic              load_xlat,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [ASID_W-1:0] asid,
  input  logic [PAIR_W-1:0] pair_idx,
  input  logic [1:0]        low_bits,
  output logic [VA_W-1:0]   bad_q,
  output logic [ASID_W-1:0] asid_q,
  output logic [PAIR_W-1:0] vpn2_q,
  output logic [1:0]        vpn2x_q,
  output logic [PAIR_W-1:0] ctx_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_q <= '0;
    end else if (load_addr) begin
      bad_q <= vaddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asid_q  <= '0;
      vpn2_q  <= '0;
      vpn2x_q <= '0;
      ctx_q   <= '0;
    end else if (load_xlat) begin
      asid_q  <= asid;
      vpn2_q  <= pair_idx;
      vpn2x_q <= low_bits;
      ctx_q   <= pair_idx;
    end
  end

  // R6
  ctx_follows_ehi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_xlat |=> (ctx_q == vpn2_q));
endmodule

// File: rtl/tlb_fault_unit.sv
module tlb_fault_unit
  import tflt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int ASID_W     = 8,
  parameter int PAGE_SHIFT = 13,
  localparam int PAIR_W    = VA_W - PAGE_SHIFT - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [1:0]        req_access,
  input  logic              req_misaligned,
  input  logic              req_hit,
  input  logic              req_entry_valid,
  input  logic              req_entry_dirty,
  output logic              flt_valid,
  input  logic              flt_ready,
  output logic [CODE_W-1:0] flt_code,
  output logic [VA_W-1:0]   cap_badvaddr,
  output logic [ASID_W-1:0] cap_ehi_asid,
  output logic [PAIR_W-1:0] cap_ehi_vpn2,
  output logic [1:0]        cap_ehi_vpn2x,
  output logic [PAIR_W-1:0] cap_ctx_badvpn2
);
  verdict_t          verdict;
  logic              take;
  logic [PAIR_W-1:0] pair_idx;
  logic [1:0]        low_bits;
  logic              fv_q;
  logic [CODE_W-1:0] code_q;

  tflt_classify u_classify (
    .access      (acc_e'(req_access)),
    .misaligned  (req_misaligned),
    .hit         (req_hit),
    .entry_valid (req_entry_valid),
    .entry_dirty (req_entry_dirty),
    .verdict     (verdict)
  );

  tflt_vpn_split #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_split (
    .vaddr    (req_vaddr),
    .pair_idx (pair_idx),
    .low_bits (low_bits)
  );

  assign req_ready = !fv_q || flt_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_q   <= 1'b0;
      code_q <= '0;
    end else if (take) begin
      fv_q <= verdict.fault;
      if (verdict.fault) code_q <= verdict.code;
    end else if (flt_ready) begin
      fv_q <= 1'b0;
    end
  end

  assign flt_valid = fv_q;
  assign flt_code  = code_q;

  tflt_capture #(.VA_W(VA_W), .ASID_W(ASID_W), .PAGE_SHIFT(PAGE_SHIFT)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_addr(take && verdict.fault),
    .load_xlat(take && verdict.fault && verdict.xlat),
    .vaddr    (req_vaddr),
    .asid     (req_asid),
    .pair_idx (pair_idx),
    .low_bits (low_bits),
    .bad_q    (cap_badvaddr),
    .asid_q   (cap_ehi_asid),
    .vpn2_q   (cap_ehi_vpn2),
    .vpn2x_q  (cap_ehi_vpn2x),
    .ctx_q    (cap_ctx_badvpn2)
  );

  // R8
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_ready) |=> (flt_valid && $stable(flt_code)));

  // R7
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(cap_badvaddr) && $stable(cap_ehi_asid) && $stable(cap_ehi_vpn2)));

  // R2
  ae_keep_ehi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_misaligned) |=> ($stable(cap_ehi_asid) && $stable(cap_ehi_vpn2)
                                  && $stable(cap_ehi_vpn2x)));

  // R5
  wp_not_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_access != 2'b10) |=> (!flt_valid || flt_code != CODE_WRITE_PROT));

  // R6
  ctx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_code >= 5'd1 && flt_code <= 5'd3) |-> (cap_ctx_badvpn2 == cap_ehi_vpn2));
endmodule

// File: tb/test_tlb_fault_unit.sv
module test_tlb_fault_unit;
  localparam int VA_W = 32;
  localparam int ASID_W = 8;
  localparam int PAGE_SHIFT = 13;
  localparam int PAIR_W = VA_W - PAGE_SHIFT - 2;

  typedef struct {
    logic [4:0]        code;
    logic [VA_W-1:0]   bad;
    logic [ASID_W-1:0] asid;
    logic [PAIR_W-1:0] vpn2;
    logic [1:0]        vpn2x;
    logic [PAIR_W-1:0] ctx;
    string             tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [ASID_W-1:0] req_asid = '0;
  logic [1:0] req_access = 2'b00;
  logic req_misaligned = 0, req_hit = 0, req_entry_valid = 0, req_entry_dirty = 0;
  logic flt_valid;
  logic flt_ready = 1;
  logic [4:0] flt_code;
  logic [VA_W-1:0] cap_badvaddr;
  logic [ASID_W-1:0] cap_ehi_asid;
  logic [PAIR_W-1:0] cap_ehi_vpn2;
  logic [1:0] cap_ehi_vpn2x;
  logic [PAIR_W-1:0] cap_ctx_badvpn2;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t sb[$];
  exp_t model;

  always #2 clk = ~clk;

  tlb_fault_unit i_tlb_fault_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_asid(req_asid), .req_access(req_access),
    .req_misaligned(req_misaligned), .req_hit(req_hit),
    .req_entry_valid(req_entry_valid), .req_entry_dirty(req_entry_dirty),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_code(flt_code),
    .cap_badvaddr(cap_badvaddr), .cap_ehi_asid(cap_ehi_asid),
    .cap_ehi_vpn2(cap_ehi_vpn2), .cap_ehi_vpn2x(cap_ehi_vpn2x),
    .cap_ctx_badvpn2(cap_ctx_badvpn2)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_caps(input exp_t e);
    chk(cap_badvaddr == e.bad, {e.tag, " badvaddr"}, 64'(cap_badvaddr), 64'(e.bad));
    chk(cap_ehi_asid == e.asid && cap_ehi_vpn2 == e.vpn2 && cap_ehi_vpn2x == e.vpn2x
        && cap_ctx_badvpn2 == e.ctx, {e.tag, " ehi/ctx"},
        {cap_ehi_asid, cap_ehi_vpn2x, cap_ehi_vpn2, cap_ctx_badvpn2},
        {e.asid, e.vpn2x, e.vpn2, e.ctx});
  endtask

  // Reference model built from the requirements.
  task automatic predict(input logic [1:0] acc, input logic [VA_W-1:0] va,
                         input logic [ASID_W-1:0] asid, input bit mis, input bit hit,
                         input bit v, input bit d, input string tag, output bit is_f);
    logic [VA_W-PAGE_SHIFT-1:0] vpn;
    bit st, fe;
    vpn = va[VA_W-1:PAGE_SHIFT];
    st = (acc == 2'b10);
    fe = (acc == 2'b00);
    is_f = 1;
    model.tag = tag;
    if (mis) begin                      // R2
      model.code = st ? 5'd5 : 5'd4;
      model.bad = va;
    end else if (!hit || !v) begin      // R3 R4
      model.code = fe ? 5'd2 : 5'd3;
    end else if (st && !d) begin        // R5
      model.code = 5'd1;
    end else begin
      is_f = 0;                         // R7
    end
    if (is_f && !mis) begin             // R6
      model.bad = va;
      model.asid = asid;
      model.vpn2 = vpn[VA_W-PAGE_SHIFT-1:2];
      model.vpn2x = vpn[1:0];
      model.ctx = vpn[VA_W-PAGE_SHIFT-1:2];
    end
  endtask

  task automatic drive(input logic [1:0] acc, input logic [VA_W-1:0] va,
                       input logic [ASID_W-1:0] asid, input bit mis, input bit hit,
                       input bit v, input bit d);
    req_access = acc; req_vaddr = va; req_asid = asid; req_misaligned = mis;
    req_hit = hit; req_entry_valid = v; req_entry_dirty = d;
    req_valid = 1;
  endtask

  task automatic send(input logic [1:0] acc, input logic [VA_W-1:0] va,
                      input logic [ASID_W-1:0] asid, input bit mis, input bit hit,
                      input bit v, input bit d, input string tag);
    bit f;
    @(negedge clk);
    predict(acc, va, asid, mis, hit, v, d, tag, f);
    if (f) sb.push_back(model);
    drive(acc, va, asid, mis, hit, v, d);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!f) begin
      #1;
      chk(flt_valid == 0, {tag, " no report"}, 64'(flt_valid), 64'd0);
      chk_caps(model);
    end
  endtask

  // Monitor: compares each report handed over to the consumer.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && flt_valid && flt_ready) begin
        if (sb.size() == 0) begin
          chk(0, "R8 unexpected report", 64'(flt_code), 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(flt_code == e.code, {e.tag, " code"}, 64'(flt_code), 64'(e.code));
          chk_caps(e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model = '{code: 5'd0, bad: '0, asid: '0, vpn2: '0, vpn2x: 2'd0, ctx: '0, tag: "R1"};
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(flt_valid == 0, "R1 flt_valid", 64'(flt_valid), 64'd0);
    chk(req_ready == 1, "R1 req_ready", 64'(req_ready), 64'd1);
    chk_caps(model);

    // Translation faults seed the capture registers first.
    send(2'b00, 32'h1234_6000, 8'h11, 0, 0, 0, 0, "R3 fetch miss");
    send(2'b01, 32'h8000_E123, 8'h22, 0, 0, 0, 0, "R3 load miss");
    send(2'b10, 32'h0000_7FFC, 8'h33, 0, 0, 0, 1, "R3 store miss");
    send(2'b00, 32'hFFFF_FFF0, 8'hFF, 0, 1, 0, 1, "R4 fetch invalid vpn2x=3");
    send(2'b10, 32'h4567_2000, 8'h44, 0, 1, 0, 0, "R4 store invalid beats dirty");
    send(2'b11, 32'h0ABC_4000, 8'h45, 0, 1, 0, 1, "R4 load2 invalid");
    send(2'b10, 32'h7654_A008, 8'h55, 0, 1, 1, 0, "R5 store not dirty");
    send(2'b00, 32'h0100_2000, 8'h05, 0, 0, 0, 0, "R6 capture split");
    // Address errors keep the ASID/VPN captures.
    send(2'b00, 32'h0000_0102, 8'h66, 1, 1, 1, 1, "R2 fetch misaligned");
    send(2'b10, 32'h0020_0001, 8'h77, 1, 1, 1, 0, "R2 store misaligned");
    send(2'b01, 32'h0300_0003, 8'h88, 1, 0, 0, 0, "R2 load misaligned over miss");
    // No fault: nothing changes.
    send(2'b01, 32'h5555_5550, 8'h99, 0, 1, 1, 0, "R5 load ignores dirty");
    send(2'b00, 32'h6666_0000, 8'hAA, 0, 1, 1, 0, "R7 fetch hit");
    send(2'b10, 32'h7777_0000, 8'hBB, 0, 1, 1, 1, "R7 store dirty hit");

    // Back-pressure on the report stream.
    flt_ready = 0;
    send(2'b01, 32'h0999_2000, 8'h12, 0, 0, 0, 0, "R8 held report A");
    @(negedge clk);
    begin
      bit f;
      predict(2'b10, 32'h0AAA_6000, 8'h13, 0, 1, 1, 0, "R8 queued report B", f);
      sb.push_back(model);
      drive(2'b10, 32'h0AAA_6000, 8'h13, 0, 1, 1, 0);
    end
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(req_ready == 0, "R8 stalled ready", 64'(req_ready), 64'd0);
      chk(flt_valid == 1 && flt_code == 5'd3, "R8 held code",
          64'(flt_code), 64'd3);
      @(negedge clk);
    end
    flt_ready = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    #1;
    chk(sb.size() == 0, "R8 reports drained", 64'(sb.size()), 64'd0);
    chk(flt_valid == 0, "R8 slot empty", 64'(flt_valid), 64'd0);

    // Back-to-back faults with a ready consumer.
    @(negedge clk);
    begin
      bit f;
      predict(2'b00, 32'h1111_8000, 8'h21, 0, 0, 0, 0, "R8 burst 1", f);
      sb.push_back(model);
      drive(2'b00, 32'h1111_8000, 8'h21, 0, 0, 0, 0);
      @(negedge clk);
      predict(2'b10, 32'h2222_A004, 8'h31, 0, 1, 1, 0, "R8 burst 2", f);
      sb.push_back(model);
      drive(2'b10, 32'h2222_A004, 8'h31, 0, 1, 1, 0);
      @(negedge clk);
      req_valid = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(sb.size() == 0, "R8 burst drained", 64'(sb.size()), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule